// File: doc/BRIEF.md
# PATA PIO Cycle Engine

This block is the host side of a parallel ATA port. It runs a single 16-bit programmed-I/O bus cycle each time software sets a start bit. During the cycle it drives the chip selects, the three device address lines, the read or write strobe and the data bus. The length of every phase of the cycle is a count of system clocks that software has programmed. Software computes each count beforehand by rounding a minimum time in nanoseconds up to a whole number of clocks.

Software prepares a cycle in four steps. It writes the device register address, writes the transmit word when the cycle is a write, sets the direction bit and then sets the start bit. The engine then steps through four phases in order: address setup, strobe, write-data hold (writes only) and recovery. When the cycle ends it clears the start bit and raises a done flag. The done flag can drive an interrupt line through a mask. A read cycle captures the device's data into a receive word. Cycles to the data port (device address 0) take their strobe width and recovery from the data-cycle timing words. Cycles to the task-file registers (addresses 1 to 15) use a separate register-cycle timing word.

Top module: `pata_pio_engine`

## Requirements
- R1: After reset the chip selects are both high (`ata_cs_n` = 2'b11), both strobes are high, `ata_dd_oe` is 0, `irq` is 0, `ata_reset_n` is 1 and the control register reads 0.
- R2: After start, the address and chip selects are valid with both strobes high for t1 clocks before the strobe falls. t1 is field [3:0] of the data timing word 0 at config offset 5.
- R3: A cycle to device address 0 holds its strobe low for the count in data timing word 1 (offset 6, bits [7:0]). Its recovery, the period after the strobe and after any hold, with the chip selects still valid, lasts the count in bits [11:4] of offset 5.
- R4: A cycle to device address 1..15 holds its strobe low for bits [15:8] of the register timing word (offset 4). Its recovery lasts bits [7:0] of that word.
- R5: With the direction bit (control bit 1) at 1, the cycle is a write. It pulses `ata_diow_n` and drives the transmit word (offset 1) on `ata_dd_out` with `ata_dd_oe` high through setup, strobe and a hold of bits [15:12] of offset 5. With the direction bit at 0, the cycle is a read. It pulses `ata_dior_n`, never enables the data bus and has no hold phase. The two strobes are never low together.
- R6: A read captures `ata_dd_in` into the receive word (offset 2) at the clock edge that ends the strobe.
- R7: The device address (offset 3, bits [3:0]) drives `ata_da` from bits [2:0]. Bit 3 picks the chip select: 0 gives `ata_cs_n` = 2'b10 and 1 gives 2'b01. Outside a cycle both chip selects are high.
- R8: When IORDY enable (control bit 4) is 1, a low `ata_iordy` keeps the strobe low past its programmed width until IORDY returns high. When the bit is 0, IORDY has no effect.
- R9: At the end of each cycle the start bit (control bit 0) reads 0 again and the done bit (offset 7, bit 0) is set. Writing 1 to the done bit clears it and writing 0 leaves it unchanged. `irq` is the done bit ANDed with mask bit 0 (offset 8).
- R10: While the use-DMA bit (control bit 2) is 1, setting the start bit launches no cycle.
- R11: `ata_reset_n` is low exactly while the device-reset bit (control bit 3) is 1.
- R12: A timing field programmed as 0 gives a phase of one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 4 | Config register offset |
| cfg_wdata | input | 16 | Config write data |
| cfg_rdata | output | 16 | Config read data for cfg_addr |
| irq | output | 1 | Masked done interrupt |
| ata_cs_n | output | 2 | Chip selects, active low |
| ata_da | output | 3 | Device address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data bus output value |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | 16 | Data bus input value |
| ata_iordy | input | 1 | Device ready, high when ready |
| ata_reset_n | output | 1 | Device reset line, active low |

## Verification
The bench runs cycles of four kinds, each with distinct setup, strobe, hold and recovery counts, so that a swapped field or a misused timing set shows up as a wrong phase length. The four kinds are data-port writes, data-port reads, register writes and register reads. It measures each phase at the pins and compares the result with the programmed fields. It also checks the chip-select and address pattern, the data driven on writes and the word captured on reads. Further runs use all-zero timing, hold IORDY low with the enable both on and off, set the use-DMA bit together with start, and work the done-bit clear and mask. These runs separate the minimum-length rule, the IORDY stretch, the launch block and the interrupt path.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

  localparam int unsigned DATA_W  = 16;
  localparam int unsigned CFG_AW  = 4;
  localparam int unsigned DEV_AW  = 4;
  localparam int unsigned CNT_W   = 8;

  localparam logic [CFG_AW-1:0] OFF_CTRL  = 4'd0;
  localparam logic [CFG_AW-1:0] OFF_TX    = 4'd1;
  localparam logic [CFG_AW-1:0] OFF_RX    = 4'd2;
  localparam logic [CFG_AW-1:0] OFF_DADDR = 4'd3;
  localparam logic [CFG_AW-1:0] OFF_RTIM  = 4'd4;
  localparam logic [CFG_AW-1:0] OFF_DTIM0 = 4'd5;
  localparam logic [CFG_AW-1:0] OFF_DTIM1 = 4'd6;
  localparam logic [CFG_AW-1:0] OFF_ISTAT = 4'd7;
  localparam logic [CFG_AW-1:0] OFF_IMASK = 4'd8;

  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_DIR   = 1;
  localparam int unsigned CB_DMA   = 2;
  localparam int unsigned CB_RST   = 3;
  localparam int unsigned CB_IORDY = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RECOV,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic [3:0] t1;
    logic [3:0] t4;
    logic [7:0] rec_reg;
    logic [7:0] stb_reg;
    logic [7:0] rec_dat;
    logic [7:0] stb_dat;
  } timing_t;

endpackage

// File: rtl/pata_pio_regs.sv
module pata_pio_regs
  import pata_pio_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = CFG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          done_pulse,
  input  logic          cap_pulse,
  input  logic [DW-1:0] cap_data,
  output logic          ctrl_start,
  output logic          ctrl_dir,
  output logic          ctrl_dma,
  output logic          ctrl_rst,
  output logic          ctrl_iordy,
  output logic [DW-1:0] tx_word,
  output logic [DEV_AW-1:0] dev_addr,
  output timing_t       timing,
  output logic          irq
);

  logic [4:0]        ctrl_q, ctrl_d;
  logic [DW-1:0]     tx_q, tx_d, rx_q, rx_d;
  logic [DEV_AW-1:0] da_q, da_d;
  logic [15:0]       rtim_q, rtim_d, dtim0_q, dtim0_d;
  logic [7:0]        dtim1_q, dtim1_d;
  logic              done_q, done_d, mask_q, mask_d;

  logic wr_ctrl, wr_tx, wr_da, wr_rtim, wr_dt0, wr_dt1, wr_ist, wr_msk;

  assign wr_ctrl = cfg_we && (cfg_addr == OFF_CTRL);
  assign wr_tx   = cfg_we && (cfg_addr == OFF_TX);
  assign wr_da   = cfg_we && (cfg_addr == OFF_DADDR);
  assign wr_rtim = cfg_we && (cfg_addr == OFF_RTIM);
  assign wr_dt0  = cfg_we && (cfg_addr == OFF_DTIM0);
  assign wr_dt1  = cfg_we && (cfg_addr == OFF_DTIM1);
  assign wr_ist  = cfg_we && (cfg_addr == OFF_ISTAT);
  assign wr_msk  = cfg_we && (cfg_addr == OFF_IMASK);

  always_comb begin
    ctrl_d  = wr_ctrl ? cfg_wdata[4:0] : ctrl_q;
    if (done_pulse) ctrl_d[CB_START] = 1'b0;
    tx_d    = wr_tx   ? cfg_wdata : tx_q;
    rx_d    = cap_pulse ? cap_data : rx_q;
    da_d    = wr_da   ? cfg_wdata[DEV_AW-1:0] : da_q;
    rtim_d  = wr_rtim ? cfg_wdata[15:0] : rtim_q;
    dtim0_d = wr_dt0  ? cfg_wdata[15:0] : dtim0_q;
    dtim1_d = wr_dt1  ? cfg_wdata[7:0] : dtim1_q;
    mask_d  = wr_msk  ? cfg_wdata[0] : mask_q;
    done_d  = done_q;
    if (wr_ist && cfg_wdata[0]) done_d = 1'b0;
    if (done_pulse)             done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      da_q    <= '0;
      rtim_q  <= '0;
      dtim0_q <= '0;
      dtim1_q <= '0;
      done_q  <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      da_q    <= da_d;
      rtim_q  <= rtim_d;
      dtim0_q <= dtim0_d;
      dtim1_q <= dtim1_d;
      done_q  <= done_d;
      mask_q  <= mask_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFF_CTRL:  cfg_rdata[4:0] = ctrl_q;
      OFF_TX:    cfg_rdata = tx_q;
      OFF_RX:    cfg_rdata = rx_q;
      OFF_DADDR: cfg_rdata[DEV_AW-1:0] = da_q;
      OFF_RTIM:  cfg_rdata[15:0] = rtim_q;
      OFF_DTIM0: cfg_rdata[15:0] = dtim0_q;
      OFF_DTIM1: cfg_rdata[7:0] = dtim1_q;
      OFF_ISTAT: cfg_rdata[0] = done_q;
      OFF_IMASK: cfg_rdata[0] = mask_q;
      default:   cfg_rdata = '0;
    endcase
  end

  assign ctrl_start = ctrl_q[CB_START];
  assign ctrl_dir   = ctrl_q[CB_DIR];
  assign ctrl_dma   = ctrl_q[CB_DMA];
  assign ctrl_rst   = ctrl_q[CB_RST];
  assign ctrl_iordy = ctrl_q[CB_IORDY];
  assign tx_word    = tx_q;
  assign dev_addr   = da_q;
  assign irq        = done_q & mask_q;

  assign timing.stb_reg = rtim_q[15:8];
  assign timing.rec_reg = rtim_q[7:0];
  assign timing.t4      = dtim0_q[15:12];
  assign timing.rec_dat = dtim0_q[11:4];
  assign timing.t1      = dtim0_q[3:0];
  assign timing.stb_dat = dtim1_q;

endmodule

// File: rtl/pata_pio_seq.sv
module pata_pio_seq
  import pata_pio_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    use_dma,
  input  logic    dir_wr,
  input  logic    iordy_en,
  input  logic    iordy,
  input  logic    sel_data,
  input  timing_t timing,
  output phase_e  phase,
  output logic    busy,
  output logic    done_pulse,
  output logic    cap_pulse
);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero, dev_ready;
  logic [7:0]    stb_sel, rec_sel;

  function automatic logic [CW-1:0] load_of(input logic [7:0] f);
    return (f == 8'd0) ? '0 : CW'(f - 8'd1);
  endfunction

  assign stb_sel   = sel_data ? timing.stb_dat : timing.stb_reg;
  assign rec_sel   = sel_data ? timing.rec_dat : timing.rec_reg;
  assign cnt_zero  = (cnt_q == '0);
  assign dev_ready = iordy || !iordy_en;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_zero ? cnt_q : cnt_q - 1'b1;
    case (ph_q)
      PH_IDLE: begin
        cnt_d = cnt_q;
        if (start && !use_dma) begin
          ph_d  = PH_SETUP;
          cnt_d = load_of({4'd0, timing.t1});
        end
      end
      PH_SETUP: if (cnt_zero) begin
        ph_d  = PH_STROBE;
        cnt_d = load_of(stb_sel);
      end
      PH_STROBE: if (cnt_zero && dev_ready) begin
        if (dir_wr) begin
          ph_d  = PH_HOLD;
          cnt_d = load_of({4'd0, timing.t4});
        end else begin
          ph_d  = PH_RECOV;
          cnt_d = load_of(rec_sel);
        end
      end
      PH_HOLD: if (cnt_zero) begin
        ph_d  = PH_RECOV;
        cnt_d = load_of(rec_sel);
      end
      PH_RECOV: if (cnt_zero) ph_d = PH_DONE;
      PH_DONE:  ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase      = ph_q;
  assign busy       = (ph_q != PH_IDLE);
  assign done_pulse = (ph_q == PH_DONE);
  assign cap_pulse  = (ph_q == PH_STROBE) && cnt_zero && dev_ready && !dir_wr;

endmodule

// File: rtl/pata_pio_engine.sv
module pata_pio_engine
  import pata_pio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  output logic                irq,
  output logic [1:0]          ata_cs_n,
  output logic [2:0]          ata_da,
  output logic                ata_dior_n,
  output logic                ata_diow_n,
  output logic [DATA_W-1:0]   ata_dd_out,
  output logic                ata_dd_oe,
  input  logic [DATA_W-1:0]   ata_dd_in,
  input  logic                ata_iordy,
  output logic                ata_reset_n
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_rsync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q[g] <= 1'b0;
        else if (g == 0) rst_sync_q[g] <= 1'b1;
        else rst_sync_q[g] <= rst_sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic              ctrl_start, ctrl_dir, ctrl_use_dma, ctrl_dev_rst, ctrl_iordy;
  logic [DATA_W-1:0] tx_word;
  logic [DEV_AW-1:0] dev_addr;
  timing_t           timing;
  phase_e            phase;
  logic              seq_busy, seq_done, seq_cap;
  logic              in_cycle, drive_data;

  pata_pio_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .done_pulse (seq_done),
    .cap_pulse  (seq_cap),
    .cap_data   (ata_dd_in),
    .ctrl_start (ctrl_start),
    .ctrl_dir   (ctrl_dir),
    .ctrl_dma   (ctrl_use_dma),
    .ctrl_rst   (ctrl_dev_rst),
    .ctrl_iordy (ctrl_iordy),
    .tx_word    (tx_word),
    .dev_addr   (dev_addr),
    .timing     (timing),
    .irq        (irq)
  );

  pata_pio_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (ctrl_start),
    .use_dma    (ctrl_use_dma),
    .dir_wr     (ctrl_dir),
    .iordy_en   (ctrl_iordy),
    .iordy      (ata_iordy),
    .sel_data   (dev_addr == '0),
    .timing     (timing),
    .phase      (phase),
    .busy       (seq_busy),
    .done_pulse (seq_done),
    .cap_pulse  (seq_cap)
  );

  assign in_cycle   = (phase == PH_SETUP) || (phase == PH_STROBE) ||
                      (phase == PH_HOLD)  || (phase == PH_RECOV);
  assign drive_data = ctrl_dir && ((phase == PH_SETUP) || (phase == PH_STROBE) ||
                                   (phase == PH_HOLD));

  assign ata_cs_n    = !in_cycle ? 2'b11 : (dev_addr[3] ? 2'b01 : 2'b10);
  assign ata_da      = in_cycle ? dev_addr[2:0] : 3'd0;
  assign ata_dior_n  = !((phase == PH_STROBE) && !ctrl_dir);
  assign ata_diow_n  = !((phase == PH_STROBE) && ctrl_dir);
  assign ata_dd_out  = tx_word;
  assign ata_dd_oe   = drive_data;
  assign ata_reset_n = !ctrl_dev_rst;

endmodule

// File: rtl/pata_pio_checker.sv
module pata_pio_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ata_cs_n,
  input logic       ata_dior_n,
  input logic       ata_diow_n,
  input logic       ata_dd_oe,
  input logic       ctrl_start,
  input logic       ctrl_use_dma,
  input logic       seq_busy,
  input logic       seq_done
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n)); // R5

  AST_OE_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ata_dd_oe |-> ata_dior_n); // R5

  AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n || !ata_diow_n) |-> (ata_cs_n != 2'b11)); // R7

  AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> (ata_cs_n == 2'b11)); // R7

  AST_DMA_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && ctrl_use_dma) |=> !seq_busy); // R10

  AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !ctrl_start); // R9

endmodule

bind pata_pio_engine pata_pio_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ata_cs_n     (ata_cs_n),
  .ata_dior_n   (ata_dior_n),
  .ata_diow_n   (ata_diow_n),
  .ata_dd_oe    (ata_dd_oe),
  .ctrl_start   (ctrl_start),
  .ctrl_use_dma (ctrl_use_dma),
  .seq_busy     (seq_busy),
  .seq_done     (seq_done)
);

// File: tb/pata_pio_engine_tb.sv
module pata_pio_engine_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        irq;
  logic [1:0]  ata_cs_n;
  logic [2:0]  ata_da;
  logic        ata_dior_n, ata_diow_n, ata_dd_oe, ata_iordy, ata_reset_n;
  logic [15:0] ata_dd_out, ata_dd_in;

  int n_checks = 0;
  int n_fail   = 0;

  pata_pio_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .ata_cs_n(ata_cs_n), .ata_da(ata_da), .ata_dior_n(ata_dior_n),
    .ata_diow_n(ata_diow_n), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
    .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy), .ata_reset_n(ata_reset_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  // Results of the last measured cycle
  int          m_setup, m_width, m_after;
  logic [1:0]  m_cs;
  logic [2:0]  m_da;
  logic        m_oe_strobe, m_oe_seen, m_rd_strobe, m_wr_strobe;
  logic [15:0] m_dout;

  // Launch a cycle (ctrl value includes start) and measure phases at the pins.
  // iordy_low: number of strobe samples after which IORDY is still held low.
  task automatic run_cycle(input logic [15:0] ctrl, input int iordy_low);
    bit seen, fin;
    m_setup = 0; m_width = 0; m_after = 0; m_oe_seen = 0;
    m_oe_strobe = 0; m_rd_strobe = 0; m_wr_strobe = 0;
    cfg_wr(4'd0, ctrl);
    seen = 0; fin = 0;
    for (int i = 0; i < 2000 && !fin; i++) begin
      @(negedge clk);
      if (ata_dd_oe) m_oe_seen = 1;
      if (!ata_dior_n || !ata_diow_n) begin
        if (!seen) begin
          m_cs = ata_cs_n; m_da = ata_da; m_oe_strobe = ata_dd_oe;
          m_dout = ata_dd_out; m_rd_strobe = !ata_dior_n; m_wr_strobe = !ata_diow_n;
        end
        seen = 1;
        m_width++;
        ata_iordy = (m_width > iordy_low);
      end else if (ata_cs_n != 2'b11) begin
        if (seen) m_after++; else m_setup++;
      end else if (seen) begin
        fin = 1;
      end
    end
    ata_iordy = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1", "cs_n", ata_cs_n, 2'b11);
    check("R1", "dior_n", ata_dior_n, 1);
    check("R1", "diow_n", ata_diow_n, 1);
    check("R1", "dd_oe", ata_dd_oe, 0);
    check("R1", "irq", irq, 0);
    check("R1", "reset_n", ata_reset_n, 1);
    cfg_rd(4'd0, v);
    check("R1", "ctrl", v, 0);
  endtask

  task automatic t_data_write;
    logic [15:0] v;
    cfg_wr(4'd3, 16'h0);
    cfg_wr(4'd5, 16'h2043);  // t4=2 rec=4 t1=3
    cfg_wr(4'd6, 16'h0005);  // width 5
    cfg_wr(4'd1, 16'hBEEF);
    run_cycle(16'h0003, 0);
    check("R2", "setup clocks", m_setup, 3);
    check("R3", "data strobe width", m_width, 5);
    check("R5", "hold+recovery after write", m_after, 6);
    check("R5", "diow used", m_wr_strobe, 1);
    check("R5", "oe in strobe", m_oe_strobe, 1);
    check("R5", "dd_out", m_dout, 16'hBEEF);
    check("R7", "cs_n addr0", m_cs, 2'b10);
    check("R7", "da addr0", m_da, 0);
    cfg_rd(4'd0, v);
    check("R9", "start self-clear", v[0], 0);
  endtask

  task automatic t_data_read;
    logic [15:0] v;
    ata_dd_in = 16'hA5C3;
    run_cycle(16'h0001, 0);
    check("R2", "setup clocks read", m_setup, 3);
    check("R3", "data strobe width read", m_width, 5);
    check("R3", "recovery read", m_after, 4);
    check("R5", "dior used", m_rd_strobe, 1);
    check("R5", "no oe on read", m_oe_seen, 0);
    cfg_rd(4'd2, v);
    check("R6", "rx word", v, 16'hA5C3);
  endtask

  task automatic t_reg_cycles;
    logic [15:0] v;
    cfg_wr(4'd4, 16'h0702);  // width 7 recovery 2
    cfg_wr(4'd3, 16'h000E);
    cfg_wr(4'd1, 16'h1234);
    run_cycle(16'h0003, 0);
    check("R4", "reg strobe width write", m_width, 7);
    check("R4", "reg hold+recovery", m_after, 4);
    check("R7", "cs_n addr E", m_cs, 2'b01);
    check("R7", "da addr E", m_da, 6);
    cfg_wr(4'd3, 16'h0007);
    ata_dd_in = 16'h5A0F;
    run_cycle(16'h0001, 0);
    check("R4", "reg strobe width read", m_width, 7);
    check("R4", "reg recovery read", m_after, 2);
    check("R7", "cs_n addr 7", m_cs, 2'b10);
    check("R7", "da addr 7", m_da, 7);
    cfg_rd(4'd2, v);
    check("R6", "rx word reg", v, 16'h5A0F);
  endtask

  task automatic t_iordy;
    cfg_wr(4'd3, 16'h0);
    cfg_wr(4'd6, 16'h0002);
    run_cycle(16'h0011, 5);
    check("R8", "stretched width", m_width, 6);
    run_cycle(16'h0001, 5);
    check("R8", "iordy ignored width", m_width, 2);
  endtask

  task automatic t_zero;
    cfg_wr(4'd5, 16'h0000);
    cfg_wr(4'd6, 16'h0000);
    run_cycle(16'h0003, 0);
    check("R12", "setup zero", m_setup, 1);
    check("R12", "width zero", m_width, 1);
    check("R12", "hold+rec zero", m_after, 2);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    cfg_rd(4'd7, v);
    check("R9", "done set", v[0], 1);
    check("R9", "irq masked", irq, 0);
    cfg_wr(4'd8, 16'h0001);
    #1 check("R9", "irq unmasked", irq, 1);
    cfg_wr(4'd7, 16'h0000);
    cfg_rd(4'd7, v);
    check("R9", "write 0 keeps done", v[0], 1);
    cfg_wr(4'd7, 16'h0001);
    cfg_rd(4'd7, v);
    check("R9", "w1c done", v[0], 0);
    check("R9", "irq cleared", irq, 0);
  endtask

  task automatic t_dma_block;
    logic [15:0] v;
    bit strobe_seen = 0;
    cfg_wr(4'd0, 16'h0005);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!ata_dior_n || !ata_diow_n || ata_cs_n != 2'b11) strobe_seen = 1;
    end
    check("R10", "no cycle with use-dma", strobe_seen, 0);
    cfg_rd(4'd7, v);
    check("R10", "no done with use-dma", v[0], 0);
    cfg_wr(4'd0, 16'h0000);
  endtask

  task automatic t_dev_reset;
    cfg_wr(4'd0, 16'h0008);
    check("R11", "reset asserted", ata_reset_n, 0);
    repeat (3) @(negedge clk);
    check("R11", "reset held", ata_reset_n, 0);
    cfg_wr(4'd0, 16'h0000);
    check("R11", "reset released", ata_reset_n, 1);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    ata_dd_in = '0; ata_iordy = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_data_write();
    t_data_read();
    t_reg_cycles();
    t_iordy();
    t_zero();
    t_irq();
    t_dma_block();
    t_dev_reset();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule